// File: doc/BRIEF.md
# Bit-Slip Word Alignment Unit

This block sits behind a deserializer whose parallel words carry no knowledge of where a real word begins. It passes those words on with a boundary that can be moved one bit at a time. A search routine elsewhere in the fabric watches the aligned output and raises a slow request line whenever the boundary should move. Every accepted rising edge of that line advances the boundary by one bit. The bit that was due to arrive first at the old boundary is thrown away for good. After as many slips as there are bits in a word, the boundary is back where it started.

Inside, the block keeps the previous and the current input word. It picks a word-wide window out of their concatenation, using the slip offset as the window start. The request line passes through a two-stage synchronizer and a stability filter, so a glitch shorter than the hold time is ignored. A level that is held high for a long time gives a single slip. Pattern search, lock status and the choice of when to slip belong to the logic that drives the request.

Top module: `bitslip_aligner`

## Requirements
- R1: After reset `slip_offset` is 0 and `out_valid` is low. The first input word gives no output. Each later input word produces, unslipped, the word that arrived just before it, so the first valid output equals the first input word.
- R2: Each accepted rising edge of `slip_req` advances `slip_offset` by exactly one. From then on every output window starts one bit later in the stream.
- R3: Output words are contiguous stretches of the input bit stream. The only gaps are one bit for each accepted slip, and the discarded bit never appears in any output word.
- R4: The slip that follows offset W-1 returns `slip_offset` to 0. One input word yields no output, so the stream stays gapless apart from the single dropped bit.
- R5: `slip_req` must hold a level for at least HOLD (default 2) consecutive clock cycles to be seen. A high pulse lasting one cycle leaves `slip_offset` and the output data unchanged.
- R6: `slip_req` held high for any number of cycles gives exactly one slip.
- R7: `slip_offset` always stays within 0 to W-1 (W default 10).
- R8: An output word is valid exactly two clock cycles after the input word that completes its window is presented with `in_valid` high. With `in_valid` low, no output is produced.
- R9: Bit 0 of `in_data` and of `out_data` is the earliest bit in time, and higher bit indices are later bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | W | Unaligned word from the deserializer, bit 0 earliest |
| in_valid | input | 1 | Qualifies `in_data` |
| slip_req | input | 1 | Slow slip request level, one slip per accepted rising edge |
| out_data | output | W | Word at the current boundary, bit 0 earliest |
| out_valid | output | 1 | Qualifies `out_data` |
| slip_offset | output | $clog2(W) | Current slip offset, 0 to W-1 |

## Verification
Four properties are checked on every cycle: the offset stays in range, the offset moves by exactly one step (wrapping at W-1) only after an internal slip pulse, two slip pulses are never back to back, and output valid always trails input valid by two cycles. Only the bench scenarios can show the data behaviour. They compare the bit content of each output word against a bit-pointer model of the serial stream across glitches, long held requests, random slip bursts and the full wrap. This shows which bits get dropped, that the first word is suppressed, and that one word is skipped on the wrap.

// File: rtl/bs_pkg.sv
package bs_pkg;
  // Default word width and minimum request hold time in cycles.
  parameter int unsigned BS_DEF_WIDTH = 10;
  parameter int unsigned BS_DEF_HOLD  = 2;
  // Synchronizer depth on the slow request line.
  parameter int unsigned BS_SYNC_DEPTH = 2;
endpackage

// File: rtl/bs_req_filter.sv
module bs_req_filter #(
  parameter int HOLD  = bs_pkg::BS_DEF_HOLD,
  parameter int SYNCN = bs_pkg::BS_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic slip_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [SYNCN-1:0] sync_q;
  logic             last_q;
  logic             lvl_q;
  logic             lvl_n;
  logic             same;
  logic [CW-1:0]    run_q;
  logic             synced;

  assign synced = sync_q[SYNCN-1];

  // A new level is taken once the synchronized input has matched itself
  // for HOLD consecutive samples.
  always_comb begin
    same  = (synced == last_q);
    lvl_n = lvl_q;
    if (same && (int'(run_q) >= HOLD - 2))
      lvl_n = synced;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
      run_q  <= '0;
      lvl_q  <= 1'b0;
      slip_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNCN-2:0], req_i};
      last_q <= synced;
      if (!same)
        run_q <= '0;
      else if (int'(run_q) < HOLD)
        run_q <= run_q + CW'(1);
      lvl_q  <= lvl_n;
      slip_o <= lvl_n & ~lvl_q;
    end
  end
endmodule

// File: rtl/bs_offset_ctr.sv
module bs_offset_ctr #(
  parameter int W = bs_pkg::BS_DEF_WIDTH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_i,
  input  logic                 take_i,
  output logic [$clog2(W)-1:0] off_o,
  output logic                 skip_o
);
  localparam int OW = $clog2(W);
  localparam logic [OW-1:0] OMAX = OW'(W - 1);

  logic wrap;
  assign wrap = step_i && (off_o == OMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_o  <= '0;
      skip_o <= 1'b1;   // first window holds no real previous word
    end else begin
      if (step_i)
        off_o <= wrap ? '0 : off_o + OW'(1);
      if (wrap)
        skip_o <= 1'b1; // a full word of bits has been consumed
      else if (take_i)
        skip_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bs_window.sv
module bs_window #(
  parameter int W = bs_pkg::BS_DEF_WIDTH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         in_data,
  input  logic                 in_valid,
  input  logic [$clog2(W)-1:0] off_i,
  input  logic                 skip_i,
  output logic                 take_o,
  output logic [W-1:0]         out_data,
  output logic                 out_valid
);
  localparam int PW = 2 * W;

  logic [W-1:0]  cur_q;
  logic [W-1:0]  prev_q;
  logic          v1_q;
  logic [PW-1:0] pair;
  logic [W-1:0]  sel;

  assign pair   = {cur_q, prev_q};
  assign take_o = v1_q;

  // Barrel selection: output bit i is stream bit off+i of the pair.
  for (genvar i = 0; i < W; i++) begin : g_sel
    always_comb sel[i] = pair[int'(off_i) + i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        prev_q <= cur_q;
        cur_q  <= in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= v1_q & ~skip_i;
      if (v1_q)
        out_data <= sel;
    end
  end
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int W    = bs_pkg::BS_DEF_WIDTH,
  parameter int HOLD = bs_pkg::BS_DEF_HOLD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         in_data,
  input  logic                 in_valid,
  input  logic                 slip_req,
  output logic [W-1:0]         out_data,
  output logic                 out_valid,
  output logic [$clog2(W)-1:0] slip_offset
);
  logic slip_pulse;
  logic skip;
  logic take;

  bs_req_filter #(.HOLD(HOLD)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .req_i  (slip_req),
    .slip_o (slip_pulse)
  );

  bs_offset_ctr #(.W(W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .step_i (slip_pulse),
    .take_i (take),
    .off_o  (slip_offset),
    .skip_o (skip)
  );

  bs_window #(.W(W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .off_i     (slip_offset),
    .skip_i    (skip),
    .take_o    (take),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int W = bs_pkg::BS_DEF_WIDTH
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [$clog2(W)-1:0] slip_offset,
  input logic                 slip_pulse
);
  // R7: offset never leaves 0..W-1
  a_r7_offset_range: assert property (@(posedge clk) disable iff (rst)
    int'(slip_offset) <= W - 1);

  // R2 / R4: a slip pulse moves the offset by one step, wrapping at W-1
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> int'(slip_offset) ==
      ((int'($past(slip_offset)) == W - 1) ? 0 : int'($past(slip_offset)) + 1));

  // R2: without a slip pulse the offset holds
  a_r2_no_spurious_move: assert property (@(posedge clk) disable iff (rst)
    !slip_pulse |=> $stable(slip_offset));

  // R6: a held request never yields back-to-back slips
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> !slip_pulse);

  // R8: output valid trails input valid by exactly two cycles
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
endmodule

bind bitslip_aligner bs_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .slip_offset (slip_offset),
  .slip_pulse  (slip_pulse)
);

// File: tb/tb_bitslip_aligner.sv
module tb_bitslip_aligner;
  localparam int W    = 10;
  localparam int OW   = $clog2(W);
  localparam int NB   = 8192;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  in_data = '0;
  logic          in_valid = 1'b0;
  logic          slip_req = 1'b0;
  logic [W-1:0]  out_data;
  logic          out_valid;
  logic [OW-1:0] slip_offset;

  logic [NB-1:0] stream;      // bit 0 is the earliest bit (R9)
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  int            wptr = 0;    // next input word index
  int            p = 0;       // stream position of next expected output bit
  int            k = 0;       // model slip offset
  bit            pend_skip = 1'b1;
  string         next_tag = "R1";
  bit            done = 1'b0;

  logic [W-1:0] exp_q[$];
  int           due_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitslip_aligner #(.W(W), .HOLD(2)) dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .slip_req(slip_req), .out_data(out_data), .out_valid(out_valid),
    .slip_offset(slip_offset)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: pops expected words and compares data and arrival cycle.
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected output", int'(out_data), -1);
      end else begin
        logic [W-1:0] e;
        int d;
        string t;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, int'(out_data), int'(e));
        check(cyc == d, "R8 latency", cyc, d);
      end
    end
  end

  // Driver: presents one word and records the window it must produce.
  task automatic send_burst(input int n);
    for (int i = 0; i < n; i++) begin
      in_data  = stream[wptr*W +: W];
      in_valid = 1'b1;
      wptr++;
      if (pend_skip) begin
        pend_skip = 1'b0;
      end else begin
        exp_q.push_back(stream[p +: W]);
        due_q.push_back(cyc + 2);
        tag_q.push_back(next_tag);
        next_tag = "R3";
        p += W;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic slip(input int hold, input string tag);
    idle(3);
    slip_req = 1'b1;
    idle(hold);
    slip_req = 1'b0;
    idle(8);
    k++;
    p++;
    next_tag = "R2";
    if (k == W) begin
      k = 0;
      pend_skip = 1'b1;
      next_tag = "R4";
    end
    check(int'(slip_offset) == k, tag, int'(slip_offset), k);
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int i = 0; i < NB; i++) begin
      stream[i] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    check(int'(slip_offset) == 0, "R1 reset offset", int'(slip_offset), 0);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    // R1 / R9: first word suppressed, then unslipped words
    send_burst(6);
    idle(4);
    // R5: one-cycle glitch is ignored
    idle(3);
    slip_req = 1'b1;
    idle(1);
    slip_req = 1'b0;
    idle(8);
    check(int'(slip_offset) == 0, "R5 glitch ignored", int'(slip_offset), 0);
    send_burst(4);
    idle(4);
    // R2: minimum-hold request gives one slip
    slip(2, "R2 offset step");
    send_burst(4);
    idle(4);
    // R6: long held request gives one slip
    slip(20, "R6 held request");
    send_burst(4);
    idle(4);
    // R3 / R7: random slip counts between bursts
    for (int it = 0; it < 30; it++) begin
      int ns;
      ns = $urandom_range(0, 3);
      for (int s = 0; s < ns; s++) slip($urandom_range(2, 4), "R7 offset");
      send_burst($urandom_range(2, 6));
      idle(4);
    end
    // R4: complete the round so the offset returns to 0
    while (k != W - 1) begin
      slip(2, "R7 offset");
    end
    send_burst(3);
    idle(4);
    slip(3, "R4 wrap to zero");
    send_burst(5);
    // R8: with in_valid low nothing more comes out
    idle(10);
    check(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);
    summary();
  end
endmodule